// File: doc/BRIEF.md
# DMA Channel Activation Arbiter

This block sits between a set of interrupt sources and a single DMA transfer engine. Each DMA channel is set up to listen to one source. It also has an enable bit and an ownership bit, which says whether the DMA side is the one that acknowledges the source. An event on a source marks every enabled channel listening to it as pending. The arbiter then starts the pending channels on the engine one at a time, lowest channel number first. It uses a start / channel-number / done handshake.

Several channels may share one source. In that case the source's flag is acknowledged only once, when the highest-priority channel that took the event is started. The other channels keep their own pending copies and run later in priority order. An event that no DMA-owning channel takes at the top of its priority order is passed on, one cycle later, to the processor interrupt path. Such an event is never acknowledged by the arbiter.

Top module: `dma_act_arb`

## Requirements
- R1: A one-cycle pulse on `src_req[s]` marks every channel with `ch_en` = 1 and a select field equal to `s` as pending. Channel `c` uses bits `[SRCW*c +: SRCW]` of `ch_src_sel`. If the engine is idle, `eng_start` is high for one cycle after the second rising edge that follows the request cycle.
- R2: When several channels are pending and the engine is idle, the lowest-numbered pending channel is started first. Its number is presented on `eng_ch` while `eng_start` is high.
- R3: `eng_start` is a single-cycle pulse. No new start is issued until `eng_done` is seen high. A channel's pending mark is cleared on the edge where `eng_done` is sampled. The next start can come one cycle after that edge, so there is exactly one idle cycle between `eng_done` and the next `eng_start`.
- R4: For each event, the highest-priority channel that took it is its leader. If the leader has `ch_own` = 1, `src_flag_clr[s]` pulses once, in the same cycle as that channel's `eng_start`. The lower-priority channels that took the same event start later and cause no further pulse.
- R5: A channel with `ch_en` = 0 takes no request, whatever its `ch_own` bit is. If no enabled channel listens to source `s`, nothing starts and the event appears on `cpu_irq[s]`.
- R6: `cpu_irq[s]` pulses one cycle after `src_req[s]`, unless that event's leader channel has `ch_own` = 1. In that case `cpu_irq[s]` stays low.
- R7: When the leader has `ch_own` = 0, `src_flag_clr[s]` never pulses for that event, even though its channels are still started.
- R8: A new request for a channel that is pending but not yet started is merged. The channel is started once, and its source flag is cleared once.
- R9: A request for the channel currently being served, arriving before its `eng_done`, is merged into that transfer. No second start follows. If the channel owns its source, `src_flag_clr` pulses on the next cycle.
- R10: While `rst` is high, and on the first cycle after it, `eng_start`, `src_flag_clr` and `cpu_irq` are low and no channel is pending.
- R11: A request for the channel being served that arrives in the same cycle as `eng_done` is kept as a new pending request. The channel is started again later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NSRC | One-cycle event pulse per interrupt source |
| ch_en | input | NCH | Per-channel enable |
| ch_own | input | NCH | Per-channel: the DMA side acknowledges the source flag |
| ch_src_sel | input | NCH*SRCW | Per-channel source number, channel c in bits [SRCW*c +: SRCW] |
| eng_done | input | 1 | Engine finished the channel it was last started on |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_ch | output | CHW | Channel number for the start |
| src_flag_clr | output | NSRC | One-cycle acknowledge pulse per source |
| cpu_irq | output | NSRC | One-cycle forward of an event to the processor path |

## Verification
The bench sweeps every mapping of four channels onto four sources, against every enable pattern and a varying ownership pattern. It checks the start order, the acknowledge count and its timing, and the processor forward. This catches a design that acknowledges once per channel rather than once per event, or that forwards an event it also acknowledges. It also catches one that lets a disabled channel start, or that starts in index order from the wrong end. Directed runs cover merging into a pending channel and merging into the running transfer. A broken design would start the channel twice in these runs, or drop the acknowledge. Another directed run sends a request in the very cycle of `eng_done`. A design that lets the clear win over the set would lose that event.

// File: rtl/dmaa_pkg.sv
package dmaa_pkg;
  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_BUSY = 1'b1
  } arb_state_e;
endpackage

// File: rtl/dmaa_route.sv
// Routes source events to channels: which channels take the event, which
// channel leads each event, and which events pass to the processor path.
module dmaa_route #(
  parameter int NCH  = 4,
  parameter int NSRC = 8,
  localparam int SRCW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]     src_req,
  input  logic [NCH-1:0]      ch_en,
  input  logic [NCH-1:0]      ch_own,
  input  logic [NCH*SRCW-1:0] ch_src_sel,
  output logic [NCH-1:0]      acc,
  output logic [NCH-1:0]      lead,
  output logic [NSRC-1:0]     cpu_fwd
);
  logic [SRCW-1:0] sel [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_sel
    assign sel[c] = ch_src_sel[SRCW*c +: SRCW];
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      acc[c] = ch_en[c] & src_req[sel[c]];
    end
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      lead[c] = acc[c];
      for (int j = 0; j < NCH; j++) begin
        if (j < c && acc[j] && sel[j] == sel[c]) lead[c] = 1'b0;
      end
    end
  end

  always_comb begin
    cpu_fwd = src_req;
    for (int c = 0; c < NCH; c++) begin
      if (lead[c] && ch_own[c]) cpu_fwd[sel[c]] = 1'b0;
    end
  end
endmodule

// File: rtl/dmaa_pick.sv
// Fixed-priority picker: lowest index wins.
module dmaa_pick #(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic [NCH-1:0] req,
  output logic           any,
  output logic [CHW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) idx = CHW'(i);
    end
  end
endmodule

// File: rtl/dma_act_arb.sv
module dma_act_arb
  import dmaa_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int NSRC = 8,
  localparam int SRCW = $clog2(NSRC),
  localparam int CHW  = $clog2(NCH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NSRC-1:0]     src_req,
  input  logic [NCH-1:0]      ch_en,
  input  logic [NCH-1:0]      ch_own,
  input  logic [NCH*SRCW-1:0] ch_src_sel,
  input  logic                eng_done,
  output logic                eng_start,
  output logic [CHW-1:0]      eng_ch,
  output logic [NSRC-1:0]     src_flag_clr,
  output logic [NSRC-1:0]     cpu_irq
);
  arb_state_e      st;
  logic [NCH-1:0]  pending;
  logic [NCH-1:0]  owed;
  logic            busy;

  logic [NCH-1:0]  acc, lead;
  logic [NSRC-1:0] cpu_fwd;
  logic            pick_any;
  logic [CHW-1:0]  pick_idx;

  logic            grant;
  logic [NCH-1:0]  gmask, dmask, act_mask, merge_act, owe_new, fire;
  logic [NSRC-1:0] clr_n;
  logic [SRCW-1:0] sel [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_sel
    assign sel[c] = ch_src_sel[SRCW*c +: SRCW];
  end

  dmaa_route #(.NCH(NCH), .NSRC(NSRC)) u_route (
    .src_req    (src_req),
    .ch_en      (ch_en),
    .ch_own     (ch_own),
    .ch_src_sel (ch_src_sel),
    .acc        (acc),
    .lead       (lead),
    .cpu_fwd    (cpu_fwd)
  );

  dmaa_pick #(.NCH(NCH)) u_pick (
    .req (pending),
    .any (pick_any),
    .idx (pick_idx)
  );

  assign busy     = (st == ARB_BUSY);
  assign grant    = !busy && pick_any;
  assign gmask    = grant ? (NCH'(1) << pick_idx) : '0;
  assign act_mask = NCH'(1) << eng_ch;
  assign dmask    = (busy && eng_done) ? act_mask : '0;
  // event led by the channel in service, before its done: fold into it
  assign merge_act = lead & ch_own & ((busy && !eng_done) ? act_mask : '0);
  assign owe_new   = lead & ch_own & ~merge_act;
  assign fire      = (gmask & (owed | owe_new)) | merge_act;

  always_comb begin
    clr_n = '0;
    for (int c = 0; c < NCH; c++) begin
      if (fire[c]) clr_n[sel[c]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ARB_IDLE;
      pending      <= '0;
      owed         <= '0;
      eng_start    <= 1'b0;
      eng_ch       <= '0;
      src_flag_clr <= '0;
      cpu_irq      <= '0;
    end else begin
      pending      <= (pending & ~dmask) | acc;
      owed         <= (owed | owe_new) & ~gmask;
      eng_start    <= grant;
      src_flag_clr <= clr_n;
      cpu_irq      <= cpu_fwd;
      if (grant) begin
        st     <= ARB_BUSY;
        eng_ch <= pick_idx;
      end else if (busy && eng_done) begin
        st <= ARB_IDLE;
      end
    end
  end
endmodule

// File: rtl/dma_act_arb_chk.sv
module dma_act_arb_chk #(
  parameter int NCH  = 4,
  parameter int NSRC = 8,
  localparam int CHW = $clog2(NCH)
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] src_req,
  input logic            eng_done,
  input logic            eng_start,
  input logic [CHW-1:0]  eng_ch,
  input logic [NSRC-1:0] src_flag_clr,
  input logic [NSRC-1:0] cpu_irq,
  input logic [NCH-1:0]  pend,
  input logic            busy
);
  a_r3_start_pulse: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);

  a_r3_no_start_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && !eng_done) |=> !eng_start);

  a_r1_start_pending: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> pend[eng_ch]);

  a_r2_lowest_first: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> ((((NCH'(1) << eng_ch) - NCH'(1)) & $past(pend)) == '0));

  a_r6_cpu_from_event: assert property (@(posedge clk) disable iff (rst)
    (cpu_irq & ~$past(src_req)) == '0);

  a_r10_reset_quiet: assert property (@(posedge clk)
    rst |=> (!eng_start && src_flag_clr == '0 && cpu_irq == '0 && pend == '0));
endmodule

bind dma_act_arb dma_act_arb_chk #(.NCH(NCH), .NSRC(NSRC)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .src_req      (src_req),
  .eng_done     (eng_done),
  .eng_start    (eng_start),
  .eng_ch       (eng_ch),
  .src_flag_clr (src_flag_clr),
  .cpu_irq      (cpu_irq),
  .pend         (pending),
  .busy         (busy)
);

// File: tb/dma_act_arb_tb.sv
`timescale 1ns/1ps
module dma_act_arb_tb;
  localparam int NCH = 4, NSRC = 4, SRCW = 2, CHW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NSRC-1:0] src_req = '0;
  logic [NCH-1:0] ch_en = '0, ch_own = '0;
  logic [NCH*SRCW-1:0] ch_src_sel = '0;
  logic eng_done = 1'b0;
  logic eng_start;
  logic [CHW-1:0] eng_ch;
  logic [NSRC-1:0] src_flag_clr, cpu_irq;

  int total = 0, bad = 0;
  int ns;
  int fl [NSRC];
  int cp [NSRC];
  logic s_start;
  logic [CHW-1:0] s_ch;
  logic [NSRC-1:0] s_flag;

  always #4 clk = ~clk;

  dma_act_arb #(.NCH(NCH), .NSRC(NSRC)) u_dut (
    .clk(clk), .rst(rst), .src_req(src_req), .ch_en(ch_en), .ch_own(ch_own),
    .ch_src_sel(ch_src_sel), .eng_done(eng_done), .eng_start(eng_start),
    .eng_ch(eng_ch), .src_flag_clr(src_flag_clr), .cpu_irq(cpu_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_cnt();
    ns = 0;
    for (int i = 0; i < NSRC; i++) begin fl[i] = 0; cp[i] = 0; end
  endtask

  task automatic step();
    @(negedge clk);
    s_start = eng_start;
    s_ch    = eng_ch;
    s_flag  = src_flag_clr;
    if (eng_start) ns++;
    for (int i = 0; i < NSRC; i++) begin
      if (src_flag_clr[i]) fl[i]++;
      if (cpu_irq[i]) cp[i]++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clr_cnt();
    repeat (3) step();
    // R10: quiet while reset is held
    chk(!eng_start && src_flag_clr == 0 && cpu_irq == 0, "R10 reset outputs",
        int'({eng_start, src_flag_clr, cpu_irq}), 0);
    rst = 1'b0;
    clr_cnt();
    repeat (4) step();
    chk(ns == 0, "R10 no start before enable", ns, 0);

    // Sweep: channel c on source bits [2c+1:2c]
    for (int idx = 0; idx < 4096; idx++) begin
      int s, n_exp, top, k_first, fa;
      int exp_ord [NCH];
      int got_ord [NCH];
      int dcnt, n;
      logic [3:0] en, own;
      ch_src_sel = idx[7:0];
      en  = idx[11:8];
      own = idx[5:2] ^ idx[11:8];
      s   = int'(idx[9:8] ^ idx[1:0]);
      ch_en = en; ch_own = own;
      n_exp = 0; top = -1;
      for (int c = 0; c < NCH; c++) begin
        if (en[c] && int'(ch_src_sel[2*c +: 2]) == s) begin
          if (top < 0) top = c;
          exp_ord[n_exp] = c;
          n_exp++;
        end
      end
      clr_cnt();
      src_req = '0; src_req[s] = 1'b1;
      step();
      src_req = '0;
      dcnt = 0; n = 0; k_first = -1; fa = 0;
      for (int k = 0; k < 18; k++) begin
        step();
        eng_done = 1'b0;
        if (s_start) begin
          if (n < NCH) got_ord[n] = int'(s_ch);
          if (n == 0) begin k_first = k; fa = int'(s_flag[s]); end
          n++;
          dcnt = 2;
        end else if (dcnt > 0) begin
          dcnt--;
          if (dcnt == 0) eng_done = 1'b1;
        end
      end
      eng_done = 1'b0;
      // R1 / R5: number of starts equals enabled listeners
      chk(n == n_exp, "R1/R5 start count", n, n_exp);
      if (n_exp > 0) chk(k_first == 0, "R1 first start timing", k_first, 0);
      // R2: order
      for (int i = 0; i < n_exp && i < n; i++)
        chk(got_ord[i] == exp_ord[i], "R2 start order", got_ord[i], exp_ord[i]);
      // R4 / R7: acknowledge count and timing
      if (top >= 0 && own[top]) begin
        chk(fl[s] == 1, "R4 single flag clear", fl[s], 1);
        chk(fa == 1, "R4 clear with first start", fa, 1);
      end else begin
        chk(fl[s] == 0, "R7 no clear when not owned", fl[s], 0);
      end
      // R6 / R5: processor forward
      chk(cp[s] == ((top >= 0 && own[top]) ? 0 : 1), "R6/R5 cpu forward",
          cp[s], (top >= 0 && own[top]) ? 0 : 1);
      for (int o = 0; o < NSRC; o++)
        if (o != s) chk(fl[o] == 0 && cp[o] == 0, "R4/R6 other sources", fl[o] + cp[o], 0);
    end

    // Directed: ch0 on src0, ch1 on src1, both owned
    ch_en = 4'b0011; ch_own = 4'b0011; ch_src_sel = 8'b0000_0100;

    // R8: repeated request for a pending channel
    clr_cnt();
    src_req = 4'b0001; step();
    src_req = 4'b0010; step();
    src_req = 4'b0010; step();
    src_req = 4'b0000; step(); step(); step();
    eng_done = 1'b1; step(); eng_done = 1'b0;
    step(); step();
    eng_done = 1'b1; step(); eng_done = 1'b0;
    repeat (6) step();
    chk(ns == 2, "R8 merged pending starts", ns, 2);
    chk(fl[1] == 1, "R8 merged pending clears", fl[1], 1);

    // R9: request for the channel in service
    clr_cnt();
    src_req = 4'b0001; step();
    src_req = 4'b0000; step();
    step();
    src_req = 4'b0001; step();
    src_req = 4'b0000;
    chk(fl[0] == 2, "R9 clear on merge into service", fl[0], 2);
    step(); step();
    eng_done = 1'b1; step(); eng_done = 1'b0;
    repeat (6) step();
    chk(ns == 1, "R9 no second start", ns, 1);
    chk(cp[0] == 0, "R9 no cpu forward", cp[0], 0);

    // R11: request in the done cycle
    clr_cnt();
    src_req = 4'b0001; step();
    src_req = 4'b0000; step();
    step();
    src_req = 4'b0001; eng_done = 1'b1; step();
    src_req = 4'b0000; eng_done = 1'b0;
    step(); step();
    eng_done = 1'b1; step(); eng_done = 1'b0;
    repeat (4) step();
    chk(ns == 2, "R11 restart after done", ns, 2);
    chk(fl[0] == 2, "R11 clears per event", fl[0], 2);

    // R3: start is a single pulse and waits for done
    clr_cnt();
    src_req = 4'b0011; step();
    src_req = 4'b0000; step();
    chk(s_start == 1'b1, "R3 start seen", int'(s_start), 1);
    repeat (5) step();
    chk(ns == 1, "R3 held while busy", ns, 1);
    eng_done = 1'b1; step(); eng_done = 1'b0;
    step();
    chk(ns == 2 && s_start && s_ch == 1, "R3 one idle cycle after done", ns, 2);
    eng_done = 1'b1; step(); eng_done = 1'b0;
    repeat (3) step();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule